// File: doc/BRIEF.md
# Exception Entry Stack Sequencer

This block performs the processor state changes needed to enter a program exception. The three causes are an access to an unmapped address, an access to a misaligned address and a breakpoint. When a trigger with a valid cause code arrives, the block captures the current instruction address, stack pointer and status word. It then issues two stores through a single-outstanding write port.

The first store writes the instruction address as a full word below the stack pointer. The second store writes the status word as a half-word eight bytes below it. Each store waits for the memory to accept it. Once the second store is accepted, the block presents three new values in the same cycle: the stack pointer lowered by eight, the status word with its interrupt-enable bit cleared, and the fixed vector address for fetch. A one-cycle done pulse marks these results.

The cause of the accepted exception stays visible on a latched output. A further valid trigger that arrives while a sequence is still running does not disturb it. Such a trigger raises a one-cycle nested warning instead.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset, mem_valid_o, done_o and nested_o are 0, cause_o is 0 (no pending cause), and new_sp_o, new_psw_o and new_pc_o are 0.
- R2: In the cycle after a trigger with a nonzero cause is taken while idle, mem_valid_o is 1 and the first store is presented: address = captured SP − 4, data = captured PC, mem_be_o = 4'b1111, mem_size_o = 2'b10 (word).
- R3: In the cycle after the first store is accepted (mem_valid_o and mem_ready_i both high at a clock edge), the second store is presented: address = captured SP − 8, data = {16'h0000, captured PSW} (little-endian, low half), mem_be_o = 4'b0011, mem_size_o = 2'b01 (half-word).
- R4: While mem_valid_o is high and mem_ready_i is low, mem_valid_o, mem_addr_o, mem_wdata_o and mem_be_o hold their values.
- R5: done_o is high for exactly one cycle, the cycle after the second store is accepted. In that cycle new_sp_o = captured SP − 8, and mem_valid_o is 0.
- R6: When done_o is high, new_psw_o equals the captured PSW with bit 11 (interrupt enable) cleared and every other bit unchanged.
- R7: When done_o is high, new_pc_o = 32'h4000_0008.
- R8: Cause codes 1 (unmapped access), 2 (misaligned access) and 3 (breakpoint) each start the sequence. From the cycle after the trigger, cause_o shows the code until the next accepted trigger or reset.
- R9: A trigger with cause code 0 is ignored: mem_valid_o stays 0, and cause_o and nested_o are unchanged.
- R10: A nonzero-cause trigger while a sequence is running sets nested_o for one cycle, the cycle after that trigger. The running sequence keeps its store values and cause_o.
- R11: new_sp_o, new_psw_o and new_pc_o hold their values after done_o until the next completion. A synchronous reset in the middle of a sequence drops mem_valid_o and clears cause_o in the cycle after it is sampled.
- R12: A trigger present in the done_o cycle is accepted as a new sequence, and nested_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Exception trigger strobe |
| trig_cause_i | input | 2 | Cause code (1 unmapped, 2 misaligned, 3 breakpoint, 0 none) |
| cur_pc_i | input | 32 | Current instruction address |
| cur_sp_i | input | 32 | Current stack pointer |
| cur_psw_i | input | 16 | Current status word |
| mem_valid_o | output | 1 | Store request valid |
| mem_ready_i | input | 1 | Store accepted by memory |
| mem_addr_o | output | 32 | Store address |
| mem_wdata_o | output | 32 | Store data, little-endian lanes |
| mem_be_o | output | 4 | Byte lane enables |
| mem_size_o | output | 2 | Store size: 2'b10 word, 2'b01 half-word |
| new_sp_o | output | 32 | Stack pointer after entry |
| new_psw_o | output | 16 | Status word after entry |
| new_pc_o | output | 32 | Fetch address after entry |
| done_o | output | 1 | One-cycle completion pulse |
| cause_o | output | 2 | Latched cause of the current exception |
| nested_o | output | 1 | One-cycle nested-trigger warning |

## Verification
A trigger sampled at a clock edge places the first store on the port one cycle later. The second store follows one cycle after the first handshake edge, and done_o with the new SP, PSW and PC follows one cycle after the second handshake edge. nested_o and cause_o also settle one cycle after the trigger edge.

The bench drives inputs and samples outputs only at falling edges. Each check therefore sits exactly one falling edge after the rising edge that should produce the result. Stall windows of several cycles are inserted before each handshake, which shows that the store fields do not move until ready is seen.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CAUSE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH_PC  = 2'd1,
    ST_PUSH_PSW = 2'd2
  } seq_state_t;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 2'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_UNMAPPED = 2'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 2'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK    = 2'd3;

  localparam logic [1:0] SIZE_HALF = 2'b01;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  function automatic logic cause_is_real(input logic [CAUSE_W-1:0] c);
    return c != CAUSE_NONE;
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               mem_fire_i,
  output logic               start_o,
  output logic               first_fire_o,
  output logic               last_fire_o,
  output logic               nested_o
);

  seq_state_t state_q, state_d;
  logic       real_trig;
  logic       nested_q;

  assign real_trig    = trig_i && cause_is_real(cause_i);
  assign start_o      = real_trig && (state_q == ST_IDLE);
  assign first_fire_o = (state_q == ST_PUSH_PC)  && mem_fire_i;
  assign last_fire_o  = (state_q == ST_PUSH_PSW) && mem_fire_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_o)      state_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (first_fire_o) state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: if (last_fire_o)  state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      nested_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      nested_q <= real_trig && (state_q != ST_IDLE);
    end
  end

  assign nested_o = nested_q;

  // R10: a nested warning only follows a cycle in which a sequence was running
  assert_nested_needs_busy_R10: assert property (@(posedge clk) disable iff (rst)
    nested_o |-> $past(state_q != ST_IDLE));

  // R5: completion always returns the sequencer to idle
  assert_last_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
    last_fire_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
  import exc_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          PSW_W  = 16,
  parameter int          IE_BIT = 11,
  parameter int          FRAME  = 8,
  parameter logic [31:0] VECTOR = 32'h4000_0008
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               last_fire_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [ADDR_W-1:0]  sp_i,
  input  logic [PSW_W-1:0]   psw_i,
  output logic [ADDR_W-1:0]  sp_cap_o,
  output logic [PSW_W-1:0]   psw_cap_o,
  output logic [ADDR_W-1:0]  new_sp_o,
  output logic [PSW_W-1:0]   new_psw_o,
  output logic [ADDR_W-1:0]  new_pc_o,
  output logic               done_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME);
  localparam logic [PSW_W-1:0]  IE_MASK     = PSW_W'(1) << IE_BIT;

  logic [ADDR_W-1:0]  sp_q;
  logic [PSW_W-1:0]   psw_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [ADDR_W-1:0]  nsp_q, npc_q;
  logic [PSW_W-1:0]   npsw_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      psw_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else if (start_i) begin
      sp_q    <= sp_i;
      psw_q   <= psw_i;
      cause_q <= cause_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nsp_q  <= '0;
      npsw_q <= '0;
      npc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_fire_i;
      if (last_fire_i) begin
        nsp_q  <= sp_q - FRAME_BYTES;
        npsw_q <= psw_q & ~IE_MASK;
        npc_q  <= VECTOR[ADDR_W-1:0];
      end
    end
  end

  assign sp_cap_o  = sp_q;
  assign psw_cap_o = psw_q;
  assign new_sp_o  = nsp_q;
  assign new_psw_o = npsw_q;
  assign new_pc_o  = npc_q;
  assign done_o    = done_q;
  assign cause_o   = cause_q;

  // R5: done is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: interrupts are masked on every completion
  assert_ie_masked_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !new_psw_o[IE_BIT]);

  // R11: results hold between completions
  assert_results_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done_o && !$past(rst) |-> $stable(new_sp_o) && $stable(new_pc_o) && $stable(new_psw_o));

endmodule

// File: rtl/exc_push_port.sv
module exc_push_port
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PSW_W  = 16
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                first_fire_i,
  input  logic                last_fire_i,
  input  logic [ADDR_W-1:0]   sp_live_i,
  input  logic [DATA_W-1:0]   pc_live_i,
  input  logic [ADDR_W-1:0]   sp_cap_i,
  input  logic [PSW_W-1:0]    psw_cap_i,
  input  logic                mem_ready_i,
  output logic                mem_fire_o,
  output logic                mem_valid_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [1:0]          mem_size_o
);

  localparam int BE_W      = DATA_W / 8;
  localparam int HALF_LANE = PSW_W / 8;
  localparam logic [ADDR_W-1:0] WORD_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] HALF_OFS = ADDR_W'(8);

  logic [BE_W-1:0] word_be, half_be;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign word_be[g] = 1'b1;
    assign half_be[g] = (g < HALF_LANE);
  end

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic [1:0]        size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      size_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      addr_q  <= sp_live_i - WORD_OFS;
      data_q  <= pc_live_i;
      be_q    <= word_be;
      size_q  <= SIZE_WORD;
    end else if (first_fire_i) begin
      valid_q <= 1'b1;
      addr_q  <= sp_cap_i - HALF_OFS;
      data_q  <= DATA_W'(psw_cap_i);
      be_q    <= half_be;
      size_q  <= SIZE_HALF;
    end else if (last_fire_i) begin
      valid_q <= 1'b0;
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_be_o    = be_q;
  assign mem_size_o  = size_q;
  assign mem_fire_o  = valid_q && mem_ready_i;

  // R4: a stalled store keeps every field
  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));

  // R2: a fresh request always opens with the word store
  assert_word_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_valid_o) |-> mem_size_o == SIZE_WORD);

  // R3: the half-word store follows the accepted word store
  assert_half_after_word_R3: assert property (@(posedge clk) disable iff (rst)
    mem_valid_o && mem_ready_i && mem_size_o == SIZE_WORD |=> mem_valid_o && mem_size_o == SIZE_HALF);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter int          PSW_W  = 16,
  parameter int          IE_BIT = 11,
  parameter logic [31:0] VECTOR = 32'h4000_0008
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic [1:0]          trig_cause_i,
  input  logic [ADDR_W-1:0]   cur_pc_i,
  input  logic [ADDR_W-1:0]   cur_sp_i,
  input  logic [PSW_W-1:0]    cur_psw_i,
  output logic                mem_valid_o,
  input  logic                mem_ready_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [1:0]          mem_size_o,
  output logic [ADDR_W-1:0]   new_sp_o,
  output logic [PSW_W-1:0]    new_psw_o,
  output logic [ADDR_W-1:0]   new_pc_o,
  output logic                done_o,
  output logic [1:0]          cause_o,
  output logic                nested_o
);

  localparam int FRAME = 8;

  logic              start, first_fire, last_fire, mem_fire;
  logic [ADDR_W-1:0] sp_cap;
  logic [PSW_W-1:0]  psw_cap;

  exc_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .cause_i      (trig_cause_i),
    .mem_fire_i   (mem_fire),
    .start_o      (start),
    .first_fire_o (first_fire),
    .last_fire_o  (last_fire),
    .nested_o     (nested_o)
  );

  exc_ctx_update #(
    .ADDR_W (ADDR_W),
    .PSW_W  (PSW_W),
    .IE_BIT (IE_BIT),
    .FRAME  (FRAME),
    .VECTOR (VECTOR)
  ) u_ctx (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .last_fire_i (last_fire),
    .cause_i     (trig_cause_i),
    .sp_i        (cur_sp_i),
    .psw_i       (cur_psw_i),
    .sp_cap_o    (sp_cap),
    .psw_cap_o   (psw_cap),
    .new_sp_o    (new_sp_o),
    .new_psw_o   (new_psw_o),
    .new_pc_o    (new_pc_o),
    .done_o      (done_o),
    .cause_o     (cause_o)
  );

  exc_push_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PSW_W  (PSW_W)
  ) u_port (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .first_fire_i (first_fire),
    .last_fire_i  (last_fire),
    .sp_live_i    (cur_sp_i),
    .pc_live_i    (cur_pc_i),
    .sp_cap_i     (sp_cap),
    .psw_cap_i    (psw_cap),
    .mem_ready_i  (mem_ready_i),
    .mem_fire_o   (mem_fire),
    .mem_valid_o  (mem_valid_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_be_o     (mem_be_o),
    .mem_size_o   (mem_size_o)
  );

  // R5: completion is reported exactly one cycle after the half-word handshake
  assert_done_after_half_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(mem_valid_o && mem_ready_i && mem_size_o == SIZE_HALF) && !mem_valid_o);

  // R7: the fetch redirect always lands on the vector
  assert_vector_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> new_pc_o == VECTOR[ADDR_W-1:0]);

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [1:0]  cause = 2'd0;
  logic [31:0] pc = '0, sp = '0;
  logic [15:0] psw = '0;
  logic        ready = 1'b0;
  logic        mvalid;
  logic [31:0] maddr, mdata;
  logic [3:0]  mbe;
  logic [1:0]  msize;
  logic [31:0] nsp, npc;
  logic [15:0] npsw;
  logic        done, nested;
  logic [1:0]  cause_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst), .trig_i(trig), .trig_cause_i(cause),
    .cur_pc_i(pc), .cur_sp_i(sp), .cur_psw_i(psw),
    .mem_valid_o(mvalid), .mem_ready_i(ready), .mem_addr_o(maddr),
    .mem_wdata_o(mdata), .mem_be_o(mbe), .mem_size_o(msize),
    .new_sp_o(nsp), .new_psw_o(npsw), .new_pc_o(npc),
    .done_o(done), .cause_o(cause_o), .nested_o(nested)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Runs a full entry; stall1/stall2 are cycles of ready low before each handshake.
  task automatic run_entry(input logic [1:0] c, input logic [31:0] p, input logic [31:0] s,
                           input logic [15:0] w, input int stall1, input int stall2);
    logic [15:0] exp_psw;
    exp_psw = w & ~16'h0800;
    trig = 1'b1; cause = c; pc = p; sp = s; psw = w; ready = 1'b0;
    step();
    trig = 1'b0; pc = 32'hDEAD_0000; sp = 32'h0BAD_0000; psw = 16'hA5A5;
    chk("R2 valid", {31'b0, mvalid}, 32'd1);
    chk("R2 addr", maddr, s - 32'd4);
    chk("R2 data", mdata, p);
    chk("R2 be", {28'b0, mbe}, 32'hF);
    chk("R2 size", {30'b0, msize}, 32'd2);
    chk("R8 cause", {30'b0, cause_o}, {30'b0, c});
    for (int i = 0; i < stall1; i++) begin
      step();
      chk("R4 hold valid", {31'b0, mvalid}, 32'd1);
      chk("R4 hold addr", maddr, s - 32'd4);
    end
    ready = 1'b1;
    step();
    ready = 1'b0;
    chk("R3 valid", {31'b0, mvalid}, 32'd1);
    chk("R3 addr", maddr, s - 32'd8);
    chk("R3 data", mdata, {16'h0, w});
    chk("R3 be", {28'b0, mbe}, 32'h3);
    chk("R3 size", {30'b0, msize}, 32'd1);
    chk("R5 no early done", {31'b0, done}, 32'd0);
    for (int i = 0; i < stall2; i++) begin
      step();
      chk("R4 hold half data", mdata, {16'h0, w});
    end
    ready = 1'b1;
    step();
    ready = 1'b0;
    chk("R5 done", {31'b0, done}, 32'd1);
    chk("R5 valid low", {31'b0, mvalid}, 32'd0);
    chk("R5 new sp", nsp, s - 32'd8);
    chk("R6 new psw", {16'b0, npsw}, {16'b0, exp_psw});
    chk("R7 new pc", npc, 32'h4000_0008);
  endtask

  task automatic t_reset();
    chk("R1 valid", {31'b0, mvalid}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 cause", {30'b0, cause_o}, 32'd0);
    chk("R1 nested", {31'b0, nested}, 32'd0);
    chk("R1 new sp", nsp, 32'd0);
    chk("R1 new pc", npc, 32'd0);
  endtask

  task automatic t_causes();
    run_entry(2'd1, 32'h0000_1234, 32'h0010_0000, 16'hFFFF, 0, 0);
    step();
    chk("R5 done one cycle", {31'b0, done}, 32'd0);
    chk("R11 sp held", nsp, 32'h000F_FFF8);
    chk("R11 psw held", {16'b0, npsw}, 32'h0000_F7FF);
    run_entry(2'd2, 32'h4000_0100, 32'h0008_0040, 16'h0800, 3, 2);
    step();
    run_entry(2'd3, 32'hCAFE_F00C, 32'h1000_0010, 16'h1234, 1, 4);
    step();
    chk("R8 cause held", {30'b0, cause_o}, 32'd3);
  endtask

  task automatic t_zero_cause();
    trig = 1'b1; cause = 2'd0; sp = 32'h100;
    step();
    trig = 1'b0;
    chk("R9 no valid", {31'b0, mvalid}, 32'd0);
    chk("R9 cause kept", {30'b0, cause_o}, 32'd3);
    chk("R9 no nested", {31'b0, nested}, 32'd0);
    step();
    chk("R9 still idle", {31'b0, mvalid}, 32'd0);
  endtask

  task automatic t_nested();
    trig = 1'b1; cause = 2'd1; pc = 32'h0000_5000; sp = 32'h0000_2000; psw = 16'h0F0F;
    step();
    cause = 2'd3; sp = 32'h0000_9000;
    step();
    trig = 1'b0;
    chk("R10 nested", {31'b0, nested}, 32'd1);
    chk("R10 cause kept", {30'b0, cause_o}, 32'd1);
    chk("R10 addr kept", maddr, 32'h0000_1FFC);
    step();
    chk("R10 nested pulse", {31'b0, nested}, 32'd0);
    ready = 1'b1;
    step();
    chk("R10 second addr", maddr, 32'h0000_1FF8);
    step();
    ready = 1'b0;
    chk("R10 done", {31'b0, done}, 32'd1);
    chk("R10 sp", nsp, 32'h0000_1FF8);
    // R12: trigger presented in the done cycle
    trig = 1'b1; cause = 2'd2; pc = 32'h0000_7777; sp = 32'h0000_3000;
    step();
    trig = 1'b0;
    chk("R12 accepted", {31'b0, mvalid}, 32'd1);
    chk("R12 addr", maddr, 32'h0000_2FFC);
    chk("R12 no nested", {31'b0, nested}, 32'd0);
    chk("R12 cause", {30'b0, cause_o}, 32'd2);
  endtask

  task automatic t_reset_mid();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R11 reset valid", {31'b0, mvalid}, 32'd0);
    chk("R11 reset cause", {30'b0, cause_o}, 32'd0);
    chk("R11 reset done", {31'b0, done}, 32'd0);
    run_entry(2'd1, 32'h0000_00A0, 32'h0000_0400, 16'h0801, 0, 1);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_causes();
    t_zero_cause();
    t_nested();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule